// File: doc/BRIEF.md
# Indirect PHY Configuration Register Bridge

This block sits between a host CPU's memory-mapped register bus and the configuration port of a serial PHY. The PHY's internal registers are not mapped directly. The host reaches them through a handful of bus registers. It loads the data word and picks a lane. It then writes one command word, which carries the PHY register address, a group-select bit and exactly one of a write bit and a read bit.

The bridge turns that command into a single transaction on a request/ready port on the PHY side. When the transaction finishes, the bridge raises an acknowledge flag that the host polls. For a read, it also latches the returned data. Writing an all-zero command word returns the bridge to idle and clears the acknowledge. Host software writes zero before and after every access.

A separate reset register drives the PHY's hard and soft reset lines directly. Host reads return data one cycle after the read strobe. Host byte offsets are: command 0x00, acknowledge 0x04, write data 0x08, read data 0x0C, lane select 0x10 and reset 0x14.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, every host register reads as zero, `phy_req` is low and both PHY reset outputs are low.
- R2: The write-data register reads back the full word written. The lane register holds only bit 0 of the written word. The reset register holds only bits 1:0. Host read data appears on the cycle after `host_rd_en`.
- R3: From idle, a command word with bit 8 set and bit 9 clear starts a PHY write. The write targets address bits [ADDR_W-1:0], group bit 10 and the latched lane bit, and carries the current write-data register. `phy_req` rises on the cycle after the command write.
- R4: A command word with bit 9 set and bit 8 clear starts a PHY read with `phy_we` low. `phy_rdata` is captured into the read-data register on the same edge at which the acknowledge sets.
- R5: While `phy_req` is high and `phy_rdy` is low, the request and all of its address, group, lane, direction and data fields stay unchanged. The transaction completes on the first edge at which `phy_rdy` is high.
- R6: Bit 0 of the acknowledge register sets only after a completed PHY transaction. A zero command word clears it and returns the bridge to idle.
- R7: While the acknowledge is set, a non-zero command word is ignored. No new request starts and the acknowledge stays set.
- R8: Two kinds of command word are ignored from idle: one with both bit 8 and bit 9 set, and a non-zero word with neither bit set. Neither starts a request or sets the acknowledge.
- R9: Command-word writes made while a transaction is in flight are ignored. They change neither the transaction nor the stored command word.
- R10: Reset register bit 1 drives `phy_hard_rst` and bit 0 drives `phy_soft_rst`.
- R11: A completed PHY write leaves the read-data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, registered |
| phy_req | output | 1 | PHY transaction request |
| phy_we | output | 1 | 1 = PHY write, 0 = PHY read |
| phy_addr | output | ADDR_W | PHY register address |
| phy_group | output | 1 | PHY register group select |
| phy_lane | output | 1 | PHY lane select |
| phy_wdata | output | DATA_W | PHY write data |
| phy_rdy | input | 1 | PHY transaction complete |
| phy_rdata | input | DATA_W | PHY read data, valid with `phy_rdy` |
| phy_hard_rst | output | 1 | PHY hard reset |
| phy_soft_rst | output | 1 | PHY soft reset |

## Verification
The assertions check several rules on every cycle:
- The request and its fields stay stable while `phy_rdy` is low.
- The acknowledge rises only after a ready handshake and never coincides with a request.
- The acknowledge persists until a zero command arrives.
- Malformed commands from idle never start a request.

Only the bench's scenarios can show the rest. That covers whether data reaches the correct lane, group and address, and whether read data returns correctly under varying PHY latency. It also covers commands dropped while busy or acknowledged, and whether the stored command and read-data registers keep their values.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} xact_state_e;

  localparam int CMD_WR_BIT  = 8;
  localparam int CMD_RD_BIT  = 9;
  localparam int CMD_GRP_BIT = 10;
  localparam int CMD_W       = CMD_GRP_BIT + 1;

  localparam int OFS_CMD   = 'h00;
  localparam int OFS_ACK   = 'h04;
  localparam int OFS_WDATA = 'h08;
  localparam int OFS_RDATA = 'h0C;
  localparam int OFS_LANE  = 'h10;
  localparam int OFS_RST   = 'h14;
endpackage

// File: rtl/phy_host_regs.sv
module phy_host_regs
  import phy_bridge_pkg::*;
#(
  parameter int HOST_AW = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               busy,
  input  logic               ack,
  input  logic [DATA_W-1:0]  rdata_cap,
  output logic [DATA_W-1:0]  wdata_q,
  output logic               lane_q,
  output logic               hard_rst_q,
  output logic               soft_rst_q
);
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      wdata_q    <= '0;
      lane_q     <= 1'b0;
      hard_rst_q <= 1'b0;
      soft_rst_q <= 1'b0;
    end else if (host_wr_en) begin
      if (host_addr == HOST_AW'(OFS_CMD) && !busy) cmd_q <= host_wdata[CMD_W-1:0];
      if (host_addr == HOST_AW'(OFS_WDATA)) wdata_q <= host_wdata;
      if (host_addr == HOST_AW'(OFS_LANE))  lane_q  <= host_wdata[0];
      if (host_addr == HOST_AW'(OFS_RST)) begin
        hard_rst_q <= host_wdata[1];
        soft_rst_q <= host_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd_en) begin
      case (host_addr)
        HOST_AW'(OFS_CMD):   host_rdata <= DATA_W'(cmd_q);
        HOST_AW'(OFS_ACK):   host_rdata <= DATA_W'(ack);
        HOST_AW'(OFS_WDATA): host_rdata <= wdata_q;
        HOST_AW'(OFS_RDATA): host_rdata <= rdata_cap;
        HOST_AW'(OFS_LANE):  host_rdata <= DATA_W'(lane_q);
        HOST_AW'(OFS_RST):   host_rdata <= DATA_W'({hard_rst_q, soft_rst_q});
        default:             host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/phy_xact_fsm.sv
module phy_xact_fsm
  import phy_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              lane_in,
  output logic              busy,
  output logic              ack,
  output logic [DATA_W-1:0] rdata_q,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              phy_group,
  output logic              phy_lane,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_rdy,
  input  logic [DATA_W-1:0] phy_rdata
);
  xact_state_e state;
  logic        cmd_valid;
  logic        cmd_zero;

  assign cmd_valid = cmd_data[CMD_WR_BIT] ^ cmd_data[CMD_RD_BIT];
  assign cmd_zero  = (cmd_data == '0);
  assign busy      = (state == ST_BUSY);
  assign ack       = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phy_req   <= 1'b0;
      phy_we    <= 1'b0;
      phy_addr  <= '0;
      phy_group <= 1'b0;
      phy_lane  <= 1'b0;
      phy_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_wr && cmd_valid) begin
          state     <= ST_BUSY;
          phy_req   <= 1'b1;
          phy_we    <= cmd_data[CMD_WR_BIT];
          phy_addr  <= cmd_data[ADDR_W-1:0];
          phy_group <= cmd_data[CMD_GRP_BIT];
          phy_lane  <= lane_in;
          phy_wdata <= wdata_in;
        end
        ST_BUSY: if (phy_rdy) begin
          state   <= ST_DONE;
          phy_req <= 1'b0;
          if (!phy_we) rdata_q <= phy_rdata;
        end
        ST_DONE: if (cmd_wr && cmd_zero) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    phy_req && !phy_rdy |=> phy_req && $stable(phy_addr) && $stable(phy_we) &&
    $stable(phy_wdata) && $stable(phy_group) && $stable(phy_lane)); // R5
  AST_ACK_FROM_RDY: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(phy_req && phy_rdy)); // R6
  AST_ZERO_IDLES: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && cmd_zero && !busy |=> !ack); // R6
  AST_ACK_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    ack |-> !phy_req); // R7
  AST_ACK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ack && !(cmd_wr && cmd_zero) |=> ack); // R7
  AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !busy && !ack && cmd_wr && !cmd_valid |=> !phy_req); // R8
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phy_bridge_pkg::*;
#(
  parameter int HOST_AW = 5,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               phy_req,
  output logic               phy_we,
  output logic [ADDR_W-1:0]  phy_addr,
  output logic               phy_group,
  output logic               phy_lane,
  output logic [DATA_W-1:0]  phy_wdata,
  input  logic               phy_rdy,
  input  logic [DATA_W-1:0]  phy_rdata,
  output logic               phy_hard_rst,
  output logic               phy_soft_rst
);
  logic              busy, ack, lane_q, cmd_wr;
  logic [DATA_W-1:0] wdata_q, rdata_cap;

  assign cmd_wr = host_wr_en && (host_addr == HOST_AW'(OFS_CMD));

  phy_host_regs #(.HOST_AW(HOST_AW), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .ack(ack), .rdata_cap(rdata_cap), .wdata_q(wdata_q),
    .lane_q(lane_q), .hard_rst_q(phy_hard_rst), .soft_rst_q(phy_soft_rst)
  );

  phy_xact_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(host_wdata[CMD_W-1:0]),
    .wdata_in(wdata_q), .lane_in(lane_q), .busy(busy), .ack(ack),
    .rdata_q(rdata_cap), .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_group(phy_group), .phy_lane(phy_lane), .phy_wdata(phy_wdata),
    .phy_rdy(phy_rdy), .phy_rdata(phy_rdata)
  );
endmodule

// File: tb/phy_reg_bridge_tb_top.sv
module phy_reg_bridge_tb_top;
  import phy_bridge_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int HOST_AW = 5;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NADDR   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [HOST_AW-1:0] host_addr = '0;
  logic [DATA_W-1:0]  host_wdata = '0, host_rdata;
  logic phy_req, phy_we, phy_group, phy_lane, phy_hard_rst, phy_soft_rst;
  logic [ADDR_W-1:0] phy_addr;
  logic [DATA_W-1:0] phy_wdata;
  logic phy_rdy = 1'b0;
  logic [DATA_W-1:0] phy_rdata = '0;

  int total = 0, bad = 0, cycles = 0, model_lat = 0, lat_cnt = 0;
  int req_rises = 0, stab_err = 0;
  logic prev_req = 1'b0;
  logic [ADDR_W-1:0] cap_addr, last_addr;
  logic cap_we, cap_grp, cap_lane, last_we, last_grp, last_lane;
  logic [DATA_W-1:0] cap_wd;
  logic [DATA_W-1:0] mem [0:1][0:1][0:NADDR-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_reg_bridge #(.HOST_AW(HOST_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_group(phy_group),
    .phy_lane(phy_lane), .phy_wdata(phy_wdata), .phy_rdy(phy_rdy),
    .phy_rdata(phy_rdata), .phy_hard_rst(phy_hard_rst), .phy_soft_rst(phy_soft_rst)
  );

  // PHY-side register file model with programmable wait states
  always @(posedge clk) begin
    if (phy_req && !phy_rdy) begin
      if (lat_cnt >= model_lat) begin
        phy_rdy <= 1'b1;
        if (phy_we) mem[phy_lane][phy_group][phy_addr] <= phy_wdata;
        phy_rdata <= mem[phy_lane][phy_group][phy_addr];
        lat_cnt <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else begin
      phy_rdy <= 1'b0;
      lat_cnt <= 0;
    end
  end

  // Request monitor: records fields at start and completion
  always @(posedge clk) begin
    prev_req <= phy_req;
    if (phy_req && !prev_req) begin
      req_rises++;
      cap_addr = phy_addr; cap_we = phy_we; cap_grp = phy_group;
      cap_lane = phy_lane; cap_wd = phy_wdata;
    end
    if (phy_req && phy_rdy) begin
      last_addr = phy_addr; last_we = phy_we; last_grp = phy_group; last_lane = phy_lane;
      if (phy_addr != cap_addr || phy_we != cap_we || phy_group != cap_grp ||
          phy_lane != cap_lane || phy_wdata != cap_wd) stab_err++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic host_write(input int ofs, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = HOST_AW'(ofs); host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input int ofs, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = HOST_AW'(ofs);
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] pattern(input int l, input int g, input int a);
    return (32'(l * 512 + g * 256 + a + 1) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] cmd_word(input bit rd, input int g, input int a);
    return (rd ? 32'h200 : 32'h100) | (32'(g) << 10) | 32'(a);
  endfunction

  task automatic access(input bit rd, input int l, input int g, input int a,
                        input logic [31:0] d, output logic [31:0] rdv, output bit got);
    logic [31:0] v;
    host_write(OFS_CMD, 0);
    host_write(OFS_LANE, 32'(l));
    host_write(OFS_WDATA, d);
    host_write(OFS_CMD, cmd_word(rd, g, a));
    got = 1'b0;
    for (int i = 0; i < 100 && !got; i++) begin
      host_read(OFS_ACK, v);
      got = v[0];
    end
    host_read(OFS_RDATA, rdv);
    host_write(OFS_CMD, 0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    total++; bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, rdv, prev_rd;
    bit got;
    int rises0;
    for (int l = 0; l < 2; l++)
      for (int g = 0; g < 2; g++)
        for (int a = 0; a < NADDR; a++) mem[l][g][a] = '0;
    idle_cycles(3);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(!phy_req && !phy_hard_rst && !phy_soft_rst, "R1 outputs",
        {29'b0, phy_req, phy_hard_rst, phy_soft_rst}, 0);
    foreach (v[i]) ;
    host_read(OFS_CMD, v);   chk(v == 0, "R1 cmd", v, 0);
    host_read(OFS_ACK, v);   chk(v == 0, "R1 ack", v, 0);
    host_read(OFS_WDATA, v); chk(v == 0, "R1 wdata", v, 0);
    host_read(OFS_RDATA, v); chk(v == 0, "R1 rdata", v, 0);
    host_read(OFS_LANE, v);  chk(v == 0, "R1 lane", v, 0);
    host_read(OFS_RST, v);   chk(v == 0, "R1 reset", v, 0);

    // R2: readback and field widths
    host_write(OFS_WDATA, 32'hCAFEF00D);
    host_read(OFS_WDATA, v); chk(v == 32'hCAFEF00D, "R2 wdata", v, 32'hCAFEF00D);
    host_write(OFS_LANE, 32'hFFFF_FFFF);
    host_read(OFS_LANE, v);  chk(v == 1, "R2 lane", v, 1);
    host_write(OFS_RST, 32'hFFFF_FFF6);
    host_read(OFS_RST, v);   chk(v == 2, "R2 reset", v, 2);

    // R10: reset outputs
    chk(phy_hard_rst && !phy_soft_rst, "R10 hard", {30'b0, phy_hard_rst, phy_soft_rst}, 2);
    host_write(OFS_RST, 1);
    chk(!phy_hard_rst && phy_soft_rst, "R10 soft", {30'b0, phy_hard_rst, phy_soft_rst}, 1);
    host_write(OFS_RST, 0);
    chk(!phy_hard_rst && !phy_soft_rst, "R10 clear", {30'b0, phy_hard_rst, phy_soft_rst}, 0);

    // R3 R4 R11: sweep every lane, group and address with varying PHY latency
    prev_rd = 0;
    for (int l = 0; l < 2; l++)
      for (int g = 0; g < 2; g++)
        for (int a = 0; a < NADDR; a++) begin
          model_lat = a % 4;
          access(1'b0, l, g, a, pattern(l, g, a), rdv, got);
          chk(got, "R3 write ack", 32'(got), 1);
          chk(last_we && last_addr == ADDR_W'(a) && last_grp == g[0] && last_lane == l[0],
              "R3 write fields", {last_we, last_lane, last_grp, 21'b0, last_addr},
              {1'b1, l[0], g[0], 21'b0, 8'(a)});
          chk(rdv == prev_rd, "R11 rdata kept", rdv, prev_rd);
          model_lat = (a + 1) % 4;
          access(1'b1, l, g, a, 32'h0, rdv, got);
          chk(got && !last_we, "R4 read ack", {31'b0, got}, 1);
          chk(rdv == pattern(l, g, a), "R4 read data", rdv, pattern(l, g, a));
          prev_rd = rdv;
        end
    // R4: second read pass shows no aliasing between lanes and groups
    for (int l = 0; l < 2; l++)
      for (int g = 0; g < 2; g++)
        for (int a = 0; a < NADDR; a += 5) begin
          model_lat = 2;
          access(1'b1, l, g, a, 32'h0, rdv, got);
          chk(rdv == pattern(l, g, a), "R4 reread", rdv, pattern(l, g, a));
        end
    chk(stab_err == 0, "R5 fields stable", stab_err, 0);

    // R9: command writes while busy are ignored
    model_lat = 30;
    rises0 = req_rises;
    host_write(OFS_CMD, 0);
    host_write(OFS_LANE, 1);
    host_write(OFS_WDATA, 32'h1234_5678);
    host_write(OFS_CMD, cmd_word(0, 0, 5));
    host_write(OFS_CMD, cmd_word(0, 1, 9));
    host_write(OFS_CMD, 0);
    host_read(OFS_ACK, v);
    chk(v == 0 && phy_req, "R5 req held during wait", {30'b0, phy_req, v[0]}, 2);
    idle_cycles(40);
    host_read(OFS_ACK, v);
    chk(v == 1, "R9 ack after ignored writes", v, 1);
    chk(req_rises == rises0 + 1 && last_addr == 5 && !last_grp, "R9 single xact",
        32'(req_rises - rises0), 1);
    chk(mem[1][0][5] == 32'h1234_5678, "R9 data landed", mem[1][0][5], 32'h1234_5678);
    host_read(OFS_CMD, v);
    chk(v == cmd_word(0, 0, 5), "R9 stored cmd", v, cmd_word(0, 0, 5));

    // R7: non-zero command while acknowledged is ignored
    model_lat = 0;
    rises0 = req_rises;
    host_write(OFS_CMD, cmd_word(1, 0, 7));
    idle_cycles(5);
    host_read(OFS_ACK, v);
    chk(v == 1 && req_rises == rises0, "R7 ignored while ack", 32'(req_rises - rises0), 0);

    // R6: zero clears ack
    host_write(OFS_CMD, 0);
    host_read(OFS_ACK, v);
    chk(v == 0, "R6 zero clears ack", v, 0);

    // R8: both bits, and neither bit, are ignored from idle
    rises0 = req_rises;
    host_write(OFS_CMD, 32'h300 | 32'h11);
    idle_cycles(5);
    host_read(OFS_ACK, v);
    chk(v == 0 && req_rises == rises0, "R8 both bits", 32'(req_rises - rises0), 0);
    host_write(OFS_CMD, 0);
    host_write(OFS_CMD, 32'h400 | 32'h3);
    idle_cycles(5);
    host_read(OFS_ACK, v);
    chk(v == 0 && req_rises == rises0, "R8 no bits", 32'(req_rises - rises0), 0);
    host_write(OFS_CMD, 0);
    // R6: after an ignored word, a valid command still works
    access(1'b1, 1, 0, 5, 32'h0, rdv, got);
    chk(got && rdv == 32'h1234_5678, "R6 recovery read", rdv, 32'h1234_5678);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule